// File: doc/BRIEF.md
# Fixed-Length I2C Command Word Receiver

This block is an I2C slave that only accepts writes. It samples the bus lines with its own system clock and watches for START and STOP conditions. After a START it takes in a 7-bit address and a direction bit. It acknowledges the address when the address equals either the device address on `dev_addr_i` or a fixed global address, and the direction bit is 0. It then takes in a fixed number of data bytes (three by default) and acknowledges each one. Once the last of them is complete, it delivers the assembled command word on a one-cycle strobe.

The block only asks for the open-drain pull-down. The pad logic drives SDA low whenever `sda_oe_o` is high. The block does not stretch the clock, does not return data and does not arbitrate. Bytes that arrive beyond the fixed frame length are not acknowledged. An address mismatch, or a read request, makes the block ignore the bus until the next START.

Top module: `i2c_word_rx`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `word_valid_o` is 0 and `word_o` is all zeros.
- R2: When the address byte carries `dev_addr_i` in its upper 7 bits (sent first, MSB first) and a 0 direction bit in its last bit, SDA is pulled low during the 9th SCL clock.
- R3: An address equal to the parameter `GLOBAL_ADDR` (default 7'h73) with direction 0 is acknowledged in the same way as R2.
- R4: A non-matching address, or a direction bit of 1, gets no acknowledge, and no following byte is acknowledged or delivered until the next START.
- R5: After an acknowledged address, data bytes 1 to 3 are each acknowledged with SDA low during their 9th clock. SDA is sampled on the SCL rising edge.
- R6: When SCL falls to end the 9th clock of the third data byte, `word_valid_o` is high for exactly one cycle. At that point `word_o` = {byte1, byte2, byte3}, with byte1 in bits 23:16. `word_o` then holds its value until the next delivery.
- R7: Data bytes after the third in the same transaction get no acknowledge and cause no further strobe.
- R8: A STOP or a repeated START before the third data byte completes produces no strobe and restarts the byte count. A full frame that follows a repeated START delivers its own word.
- R9: `sda_oe_o` rises only while SCL is low, after the 8th falling edge of a byte. It falls after the 9th falling edge, so a 1 bit sent in the next byte reads back as 1 on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| dev_addr_i | input | 7 | Local device address |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| word_valid_o | output | 1 | One-cycle strobe for a completed word |
| word_o | output | 24 | Last delivered command word |

## Verification
The bench drives a bit-level bus master that models the wired-AND line. The corner cases it targets are these:
- Overlong frames: a design that counted bytes wrongly would acknowledge the fourth byte or strobe a second time.
- Short frames ended by STOP or by a repeated START: a counter that was not cleared would strobe early, or deliver a word mixing bytes from two frames.
- Read-direction and foreign addresses: a slave that failed to ignore the bus would acknowledge the data that follows.
- Timing of the acknowledge release: a release that came too late would pull down the first bit of the next byte.
- The global address after a change of `dev_addr_i`: this catches comparisons against the wrong source.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/i2c_word_sync.sv
module i2c_word_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '1;  // idle bus is high
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_word_cond.sv
module i2c_word_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_word_ctrl.sv
module i2c_word_ctrl
  import i2c_word_pkg::*;
#(
  parameter int         NUM_BYTES   = 3,
  parameter logic [6:0] GLOBAL_ADDR = 7'h73,
  localparam int        WORD_W      = NUM_BYTES * 8,
  localparam int        BCNT_W      = $clog2(NUM_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [6:0]        dev_addr_i,
  output logic              ack_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [BCNT_W-1:0] LAST_BYTE = BCNT_W'(NUM_BYTES - 1);
  localparam logic [BCNT_W-1:0] FULL_CNT  = BCNT_W'(NUM_BYTES);

  rx_state_e         state_q;
  logic [3:0]        bit_cnt_q;
  logic [BCNT_W-1:0] byte_cnt_q;
  logic [7:0]        shreg_q;
  logic [WORD_W-1:0] acc_q, word_q;
  logic              ack_q, valid_q;
  logic              addr_hit, active;

  assign addr_hit = ~shreg_q[0] &
                    ((shreg_q[7:1] == dev_addr_i) || (shreg_q[7:1] == GLOBAL_ADDR));
  assign active   = (state_q == ST_ADDR) || (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      shreg_q    <= '0;
      acc_q      <= '0;
      word_q     <= '0;
      ack_q      <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start_i || stop_i) begin
        state_q    <= start_i ? ST_ADDR : ST_IDLE;
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
        ack_q      <= 1'b0;
      end else if (active) begin
        if (scl_rise_i) begin
          if (bit_cnt_q < 4'd8) shreg_q <= {shreg_q[6:0], sda_s_i};
          if (bit_cnt_q != 4'd9) bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (scl_fall_i) begin
          if (bit_cnt_q == 4'd8) begin
            // byte complete: decide acknowledge slot
            if (state_q == ST_ADDR) begin
              if (addr_hit) ack_q <= 1'b1;
              else state_q <= ST_SKIP;
            end else if (byte_cnt_q < FULL_CNT) begin
              ack_q <= 1'b1;
              acc_q <= {acc_q[WORD_W-9:0], shreg_q};
            end
          end else if (bit_cnt_q == 4'd9) begin
            ack_q     <= 1'b0;
            bit_cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              state_q <= ST_DATA;
            end else if (byte_cnt_q < FULL_CNT) begin
              byte_cnt_q <= byte_cnt_q + 1'b1;
              if (byte_cnt_q == LAST_BYTE) begin
                valid_q <= 1'b1;
                word_q  <= acc_q;
              end
            end
          end
        end
      end
    end
  end

  assign ack_o   = ack_q;
  assign valid_o = valid_q;
  assign word_o  = word_q;
endmodule

// File: rtl/i2c_word_rx.sv
module i2c_word_rx #(
  parameter int         NUM_BYTES   = 3,
  parameter logic [6:0] GLOBAL_ADDR = 7'h73,
  parameter int         SYNC_STAGES = 2,
  localparam int        WORD_W      = NUM_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [6:0]        dev_addr_i,
  output logic              sda_oe_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_word_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  i2c_word_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_word_ctrl #(.NUM_BYTES(NUM_BYTES), .GLOBAL_ADDR(GLOBAL_ADDR)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .dev_addr_i (dev_addr_i),
    .ack_o      (sda_oe_o),
    .valid_o    (word_valid_o),
    .word_o     (word_o)
  );
endmodule

// File: rtl/i2c_word_rx_chk.sv
module i2c_word_rx_chk #(
  parameter int W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         scl_s,
  input logic         start_det,
  input logic         sda_oe_o,
  input logic         word_valid_o,
  input logic [W-1:0] word_o
);
  // R6
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  // R6
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(word_o));

  // R9
  ack_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  // R9
  ack_fall_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_s);

  // R8
  start_clears_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);

  // R6
  strobe_ack_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !sda_oe_o);
endmodule

bind i2c_word_rx i2c_word_rx_chk #(.W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_s        (scl_s),
  .start_det    (start_det),
  .sda_oe_o     (sda_oe_o),
  .word_valid_o (word_valid_o),
  .word_o       (word_o)
);

// File: tb/i2c_word_rx_test.sv
module i2c_word_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;   // system clocks per SCL phase
  localparam logic [6:0] GADDR = 7'h73;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [6:0]  dev_addr = 7'h22;
  logic        sda_oe;
  logic        word_valid;
  logic [23:0] word;
  logic        sda_line;

  int checks = 0;
  int fails  = 0;
  logic [23:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_word_rx uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .dev_addr_i   (dev_addr),
    .sda_oe_o     (sda_oe),
    .word_valid_o (word_valid),
    .word_o       (word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected words as strobes appear (R6)
  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (exp_q.size() == 0) chk("R4/R7/R8 unexpected strobe", {8'h0, word}, 32'hDEAD);
      else chk("R6 word", {8'h0, word}, {8'h0, exp_q.pop_front()});
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b0; wait_clk(HALF);
    scl_m = 1'b0; wait_clk(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b1; wait_clk(HALF);
  endtask

  // sends a byte, returns 1 when the slave acknowledged
  task automatic send_byte(input logic [7:0] b, input bit check_msb, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(HALF);
      scl_m = 1'b1; wait_clk(HALF/2);
      if (check_msb && i == 7) chk("R9 released before next byte", {31'h0, sda_line}, {31'h0, b[i]});
      wait_clk(HALF/2);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF/2);
    acked = ~sda_line;
    wait_clk(HALF/2);
    scl_m = 1'b0;
  endtask

  // driver: computes expectations from the requirements and pushes words
  task automatic frame(input logic [6:0] a, input bit rw, input int n,
                       input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                       input logic [7:0] d3, input bit do_stop, input string tag);
    logic [7:0] db [4];
    bit hit, ak;
    db[0] = d0; db[1] = d1; db[2] = d2; db[3] = d3;
    hit = !rw && (a == dev_addr || a == GADDR);
    if (hit && n >= 3) exp_q.push_back({d0, d1, d2});
    bus_start();
    send_byte({a, rw}, 1'b0, ak);
    chk({tag, " addr ack"}, {31'h0, ak}, {31'h0, hit});
    for (int i = 0; i < n; i++) begin
      send_byte(db[i % 4], hit && i > 0 && i < 3, ak);
      chk({tag, " data ack"}, {31'h0, ak}, {31'h0, hit && i < 3});
    end
    if (do_stop) bus_stop();
    wait_clk(HALF);
  endtask

  initial begin : watchdog
    wait_clk(150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(3);
    chk("R1 sda_oe", {31'h0, sda_oe}, 32'h0);
    chk("R1 valid", {31'h0, word_valid}, 32'h0);
    chk("R1 word", {8'h0, word}, 32'h0);
    rst_n = 1'b1;
    wait_clk(4);

    // R2 R5 R6: local address, three bytes
    frame(7'h22, 1'b0, 3, 8'hA5, 8'h81, 8'hFF, 8'h00, 1'b1, "R2/R5");
    chk("R6 word holds", {8'h0, word}, 32'hA581FF);
    // R3: global address
    frame(GADDR, 1'b0, 3, 8'h80, 8'hC3, 8'h3C, 8'h00, 1'b1, "R3");
    // R4: foreign address, then read direction
    frame(7'h23, 1'b0, 3, 8'h11, 8'h22, 8'h33, 8'h00, 1'b1, "R4 mismatch");
    frame(7'h22, 1'b1, 3, 8'h44, 8'h55, 8'h66, 8'h00, 1'b1, "R4 read dir");
    chk("R4 word unchanged", {8'h0, word}, 32'h80C33C);
    // R7: overlong frame
    frame(7'h22, 1'b0, 4, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 1'b1, "R7");
    frame(7'h22, 1'b0, 6, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1, "R7 long");
    // R8: short frame ended by STOP
    frame(7'h22, 1'b0, 2, 8'hEE, 8'hDD, 8'h00, 8'h00, 1'b1, "R8 stop");
    chk("R8 word after short", {8'h0, word}, 32'h010203);
    // R8: short frame then repeated START into a full frame
    frame(GADDR, 1'b0, 2, 8'h77, 8'h66, 8'h00, 8'h00, 1'b0, "R8 rstart");
    frame(7'h22, 1'b0, 3, 8'h5A, 8'hC7, 8'h18, 8'h00, 1'b1, "R8 after rstart");
    // R2/R3: changed local address; old one must no longer match
    dev_addr = 7'h4F;
    frame(7'h22, 1'b0, 3, 8'h12, 8'h34, 8'h56, 8'h00, 1'b1, "R4 old addr");
    frame(7'h4F, 1'b0, 3, 8'hF1, 8'hE2, 8'hD3, 8'h00, 1'b1, "R2 new addr");
    frame(GADDR, 1'b0, 3, 8'h0F, 8'hF0, 8'hAA, 8'h00, 1'b1, "R3 again");

    wait_clk(20);
    chk("R6 all words delivered", exp_q.size(), 32'h0);
    chk("R6 final word", {8'h0, word}, 32'h0FF0AA);
    chk("R9 idle sda_oe", {31'h0, sda_oe}, 32'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule